// File: doc/BRIEF.md
# Supply Voltage Emergency Controller

This block watches a digital supply-voltage code that an on-chip sensor delivers once per cycle. It sorts each sample into one of five bands, built from two nested pairs of thresholds: an inner control pair and an outer emergency pair. It then drives two actuator requests. The throttle request cuts current draw when the supply sags. The phantom-fire request adds current draw when the supply rises. Each request is held until the supply has settled back inside the control band for a programmable number of samples.

Any move of the supply outward across a threshold is an emergency. Crossing an inner threshold is a soft emergency, and crossing an outer one is a hard emergency. For each emergency the block captures the address of the most recently retired branch, so that a software layer can locate the code sequence that caused the current swing. The capture goes into a one-deep record, which is handed to software over a valid/ready handshake. A sticky flag reports records that were overwritten before software read them. Two saturating counters keep a tally of soft and hard emergencies.

The sensor samples arrive with a valid qualifier and cannot be stalled. The event record is the only back-pressured interface. While `evt_valid` is high and `evt_ready` is low, the record holds its contents, unless a newer emergency replaces it.

Top module: `vg_guard_top`

## Requirements
- R1: Band encoding is 0 = hard-under (code < hard_lo), 1 = soft-under (hard_lo <= code < soft_lo), 2 = in-band, 3 = soft-over (soft_hi < code <= hard_hi) and 4 = hard-over (code > hard_hi). `band` updates on the clock edge that takes a valid sample and holds while `smp_valid` is low.
- R2: A valid sample in band 0 or 1 sets `throttle` at that edge. A valid sample in band 3 or 4 sets `phantom` at that edge.
- R3: `throttle` and `phantom` are never high together. A sample on the opposite side switches from one request to the other at a single edge.
- R4: An active request clears on the Nth consecutive valid in-band sample, where N is the hold length. Cycles without a valid sample neither advance nor reset this count. A hold length of 0 behaves as 1.
- R5: An emergency fires on a valid sample in bands 0, 1, 3 or 4 whenever the previous band was in-band, was on the other side, or was shallower on the same side. The record marks hard (bands 0 and 4) or soft, and over (bands 3 and 4) or under. Moving back toward the in-band range fires nothing.
- R6: The captured address is that of the latest branch reported with `br_valid`, including a branch reported in the same cycle as the triggering sample.
- R7: A record raises `evt_valid` and holds its fields stable until the cycle in which `evt_ready` is high. `evt_valid` then drops, unless a new emergency loads at the same edge.
- R8: An emergency that fires while a record is pending and not being accepted sets the sticky `evt_ovf` and overwrites the record with the newer event.
- R9: The soft and hard counters are 16 bits wide and saturate at 65535. A configuration write to address 5 clears both counters and `evt_ovf`.
- R10: Configuration addresses 0 to 3 hold hard_lo, soft_lo, soft_hi and hard_hi, with reset values 950, 970, 1030 and 1050 mV. Address 4 holds the hold length, with reset value 4. A write takes effect for the sample in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sensor sample qualifier |
| smp_code | input | 12 | Supply voltage in millivolts |
| br_valid | input | 1 | A branch retired this cycle |
| br_addr | input | 32 | Address of the retired branch |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 12 | Configuration write data |
| band | output | 3 | Band of the last valid sample |
| throttle | output | 1 | Resource-throttle request |
| phantom | output | 1 | Phantom-fire request |
| evt_valid | output | 1 | Emergency record pending |
| evt_ready | input | 1 | Software accepts the record |
| evt_hard | output | 1 | Record is a hard emergency |
| evt_over | output | 1 | Record is an overvoltage |
| evt_addr | output | 32 | Captured branch address |
| evt_ovf | output | 1 | Sticky record-overwrite flag |
| soft_cnt | output | 16 | Soft emergency count |
| hard_cnt | output | 16 | Hard emergency count |

## Verification
The assertions check the following on every cycle:
- the two requests never overlap;
- each request follows an under or over sample one edge later;
- the band holds when no sample arrives;
- a pending record stays stable while back-pressured;
- the overflow flag rises only on a collision;
- the soft counter saturates.

Some behaviours can only be shown by the bench's voltage ramps:
- the exact threshold boundaries;
- the hold length counting across idle cycles;
- which crossings fire and which do not;
- the captured branch address;
- the effect of reprogrammed thresholds.

The scoreboard matches every accepted record against the expected type, polarity and address.

// File: rtl/vg_pkg.sv
package vg_pkg;
  typedef enum logic [2:0] {
    BAND_HARD_LO = 3'd0,
    BAND_SOFT_LO = 3'd1,
    BAND_OK      = 3'd2,
    BAND_SOFT_HI = 3'd3,
    BAND_HARD_HI = 3'd4
  } band_t;

  // threshold slots, ordered from lowest to highest voltage
  localparam int unsigned THR_N      = 4;
  localparam int unsigned THR_HLO    = 0;
  localparam int unsigned THR_SLO    = 1;
  localparam int unsigned THR_SHI    = 2;
  localparam int unsigned THR_HHI    = 3;
  localparam logic [2:0]  ADDR_HOLD  = 3'd4;
  localparam logic [2:0]  ADDR_CLEAR = 3'd5;

  function automatic logic [1:0] band_depth(band_t b);
    case (b)
      BAND_HARD_LO, BAND_HARD_HI: return 2'd2;
      BAND_SOFT_LO, BAND_SOFT_HI: return 2'd1;
      default:                    return 2'd0;
    endcase
  endfunction

  function automatic logic band_is_over(band_t b);
    return (b == BAND_SOFT_HI) || (b == BAND_HARD_HI);
  endfunction

  function automatic logic band_is_under(band_t b);
    return (b == BAND_SOFT_LO) || (b == BAND_HARD_LO);
  endfunction
endpackage

// File: rtl/vg_cfg_regs.sv
module vg_cfg_regs
  import vg_pkg::*;
#(
  parameter int unsigned VW       = 12,
  parameter int unsigned HOLDW    = 8,
  parameter int unsigned DEF_HLO  = 950,
  parameter int unsigned DEF_SLO  = 970,
  parameter int unsigned DEF_SHI  = 1030,
  parameter int unsigned DEF_HHI  = 1050,
  parameter int unsigned DEF_HOLD = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [2:0]                 cfg_addr,
  input  logic [VW-1:0]              cfg_wdata,
  output logic [THR_N-1:0][VW-1:0]   thr_o,
  output logic [HOLDW-1:0]           hold_o,
  output logic                       clr_o
);
  localparam logic [THR_N-1:0][VW-1:0] THR_DEF =
    {VW'(DEF_HHI), VW'(DEF_SHI), VW'(DEF_SLO), VW'(DEF_HLO)};

  logic [VW-1:0]    thr_q [THR_N];
  logic [HOLDW-1:0] hold_q;

  for (genvar i = 0; i < THR_N; i++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_q[i] <= THR_DEF[i];
      else if (cfg_we && cfg_addr == 3'(i))
        thr_q[i] <= cfg_wdata;
    end
    assign thr_o[i] = thr_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= HOLDW'(DEF_HOLD);
    else if (cfg_we && cfg_addr == ADDR_HOLD)
      hold_q <= cfg_wdata[HOLDW-1:0];
  end

  assign hold_o = hold_q;
  assign clr_o  = cfg_we && (cfg_addr == ADDR_CLEAR);
endmodule

// File: rtl/vg_classifier.sv
module vg_classifier
  import vg_pkg::*;
#(
  parameter int unsigned VW = 12
) (
  input  logic [VW-1:0]            code,
  input  logic [THR_N-1:0][VW-1:0] thr,
  output band_t                    band
);
  always_comb begin
    if (code < thr[THR_HLO])      band = BAND_HARD_LO;
    else if (code < thr[THR_SLO]) band = BAND_SOFT_LO;
    else if (code > thr[THR_HHI]) band = BAND_HARD_HI;
    else if (code > thr[THR_SHI]) band = BAND_SOFT_HI;
    else                          band = BAND_OK;
  end
endmodule

// File: rtl/vg_actuator.sv
module vg_actuator
  import vg_pkg::*;
#(
  parameter int unsigned HOLDW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  band_t            band,
  input  logic [HOLDW-1:0] hold_len,
  output logic             throttle,
  output logic             phantom
);
  logic             throt_q, phan_q;
  logic [HOLDW-1:0] cnt_q;
  logic [HOLDW:0]   cnt_nxt;
  logic             hold_done;

  assign cnt_nxt   = {1'b0, cnt_q} + 1'b1;
  assign hold_done = cnt_nxt >= {1'b0, hold_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      throt_q <= 1'b0;
      phan_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (smp_valid) begin
      if (band_is_under(band)) begin
        throt_q <= 1'b1;
        phan_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (band_is_over(band)) begin
        throt_q <= 1'b0;
        phan_q  <= 1'b1;
        cnt_q   <= '0;
      end else if (throt_q || phan_q) begin
        if (hold_done) begin
          throt_q <= 1'b0;
          phan_q  <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q   <= cnt_nxt[HOLDW-1:0];
        end
      end
    end
  end

  assign throttle = throt_q;
  assign phantom  = phan_q;
endmodule

// File: rtl/vg_event_rec.sv
module vg_event_rec
  import vg_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  band_t           band_new,
  input  band_t           band_old,
  input  logic [AW-1:0]   br_addr,
  input  logic            clr,
  input  logic            evt_ready,
  output logic            fire,
  output logic            evt_valid,
  output logic            evt_hard,
  output logic            evt_over,
  output logic [AW-1:0]   evt_addr,
  output logic            evt_ovf,
  output logic [CNTW-1:0] soft_cnt,
  output logic [CNTW-1:0] hard_cnt
);
  logic [1:0] d_new, d_old;
  logic       o_new, o_old;

  assign d_new = band_depth(band_new);
  assign d_old = band_depth(band_old);
  assign o_new = band_is_over(band_new);
  assign o_old = band_is_over(band_old);
  assign fire  = smp_valid && (d_new != 2'd0) &&
                 ((d_old == 2'd0) || (o_new != o_old) || (d_new > d_old));

  logic          v_q, h_q, o_q, ovf_q;
  logic [AW-1:0] a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      h_q <= 1'b0;
      o_q <= 1'b0;
      a_q <= '0;
    end else if (fire) begin
      v_q <= 1'b1;
      h_q <= (d_new == 2'd2);
      o_q <= o_new;
      a_q <= br_addr;
    end else if (v_q && evt_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= 1'b0;
    else if (clr)
      ovf_q <= 1'b0;
    else if (fire && v_q && !evt_ready)
      ovf_q <= 1'b1;
  end

  // index 0 counts soft, index 1 counts hard
  logic [1:0]      inc;
  logic [CNTW-1:0] cnt_q [2];
  assign inc[0] = fire && (d_new == 2'd1);
  assign inc[1] = fire && (d_new == 2'd2);

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[k] <= '0;
      else if (clr)
        cnt_q[k] <= '0;
      else if (inc[k] && !(&cnt_q[k]))
        cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign evt_valid = v_q;
  assign evt_hard  = h_q;
  assign evt_over  = o_q;
  assign evt_addr  = a_q;
  assign evt_ovf   = ovf_q;
  assign soft_cnt  = cnt_q[0];
  assign hard_cnt  = cnt_q[1];
endmodule

// File: rtl/vg_guard_top.sv
module vg_guard_top
  import vg_pkg::*;
#(
  parameter int unsigned VW    = 12,
  parameter int unsigned AW    = 32,
  parameter int unsigned HOLDW = 8,
  parameter int unsigned CNTW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [VW-1:0]   smp_code,
  input  logic            br_valid,
  input  logic [AW-1:0]   br_addr,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [VW-1:0]   cfg_wdata,
  output logic [2:0]      band,
  output logic            throttle,
  output logic            phantom,
  output logic            evt_valid,
  input  logic            evt_ready,
  output logic            evt_hard,
  output logic            evt_over,
  output logic [AW-1:0]   evt_addr,
  output logic            evt_ovf,
  output logic [CNTW-1:0] soft_cnt,
  output logic [CNTW-1:0] hard_cnt
);
  logic [THR_N-1:0][VW-1:0] thr;
  logic [HOLDW-1:0]         hold_len;
  logic                     cfg_clr;
  band_t                    cls_band, band_q;
  logic [AW-1:0]            br_last_q, br_eff;
  logic                     evt_fire;

  vg_cfg_regs #(.VW(VW), .HOLDW(HOLDW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .thr_o(thr), .hold_o(hold_len), .clr_o(cfg_clr)
  );

  vg_classifier #(.VW(VW)) u_cls (
    .code(smp_code), .thr(thr), .band(cls_band)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         band_q <= BAND_OK;
    else if (smp_valid) band_q <= cls_band;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        br_last_q <= '0;
    else if (br_valid) br_last_q <= br_addr;
  end
  assign br_eff = br_valid ? br_addr : br_last_q;

  vg_actuator #(.HOLDW(HOLDW)) u_act (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .band(cls_band),
    .hold_len(hold_len), .throttle(throttle), .phantom(phantom)
  );

  vg_event_rec #(.AW(AW), .CNTW(CNTW)) u_evt (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .band_new(cls_band),
    .band_old(band_q), .br_addr(br_eff), .clr(cfg_clr), .evt_ready(evt_ready),
    .fire(evt_fire), .evt_valid(evt_valid), .evt_hard(evt_hard),
    .evt_over(evt_over), .evt_addr(evt_addr), .evt_ovf(evt_ovf),
    .soft_cnt(soft_cnt), .hard_cnt(hard_cnt)
  );

  assign band = band_q;
endmodule

// File: rtl/vg_guard_chk.sv
module vg_guard_chk
  import vg_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_valid,
  input logic [2:0]      cls_band,
  input logic [2:0]      band,
  input logic            throttle,
  input logic            phantom,
  input logic            evt_valid,
  input logic            evt_ready,
  input logic [AW-1:0]   evt_addr,
  input logic            evt_ovf,
  input logic            evt_fire,
  input logic            clr,
  input logic [CNTW-1:0] soft_cnt
);
  // R3
  mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(throttle && phantom));

  // R2
  throttle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (cls_band == BAND_SOFT_LO || cls_band == BAND_HARD_LO)) |=> throttle);

  // R2
  phantom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (cls_band == BAND_SOFT_HI || cls_band == BAND_HARD_HI)) |=> phantom);

  // R1
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(band));

  // R7
  rec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && !evt_fire) |=> (evt_valid && $stable(evt_addr)));

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_ovf) |-> $past(evt_fire && evt_valid && !evt_ready));

  // R9
  soft_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&soft_cnt) && !clr) |=> (&soft_cnt));
endmodule

bind vg_guard_top vg_guard_chk #(.AW(AW), .CNTW(CNTW)) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cls_band(cls_band),
  .band(band), .throttle(throttle), .phantom(phantom), .evt_valid(evt_valid),
  .evt_ready(evt_ready), .evt_addr(evt_addr), .evt_ovf(evt_ovf),
  .evt_fire(evt_fire), .clr(cfg_clr), .soft_cnt(soft_cnt)
);

// File: tb/test_vg_guard_top.sv
`timescale 1ns/1ps
module test_vg_guard_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_code = '0;
  logic        br_valid = 1'b0;
  logic [31:0] br_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [2:0]  band;
  logic        throttle, phantom, evt_valid, evt_hard, evt_over, evt_ovf;
  logic        evt_ready = 1'b1;
  logic [31:0] evt_addr;
  logic [15:0] soft_cnt, hard_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [33:0] exp_q [$];

  always #5 clk = ~clk;

  vg_guard_top i_vg_guard_top (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .br_valid(br_valid), .br_addr(br_addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .band(band), .throttle(throttle), .phantom(phantom),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_hard(evt_hard),
    .evt_over(evt_over), .evt_addr(evt_addr), .evt_ovf(evt_ovf),
    .soft_cnt(soft_cnt), .hard_cnt(hard_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one valid sample for one cycle; returns just after the capturing edge
  task automatic send(input int v, input logic bv = 1'b0, input logic [31:0] ba = '0);
    @(posedge clk); #2;
    smp_valid = 1'b1; smp_code = 12'(v); br_valid = bv; br_addr = ba;
    @(posedge clk); #2;
    smp_valid = 1'b0; br_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [2:0] a, input int d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 12'(d);
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  // scoreboard driver side: {hard, over, addr}
  task automatic expect_evt(input logic h, input logic o, input logic [31:0] a);
    exp_q.push_back({h, o, a});
  endtask

  // scoreboard monitor: one compare per accepted record
  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5: unexpected record actual %h expected none",
                 {evt_hard, evt_over, evt_addr});
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        if ({evt_hard, evt_over, evt_addr} !== e) begin
          n_fail++;
          $display("FAIL R5/R6: record actual %h expected %h",
                   {evt_hard, evt_over, evt_addr}, e);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check("R1 reset band", band, 2);
    check("R2 reset throttle", throttle, 0);
    check("R2 reset phantom", phantom, 0);
    check("R7 reset valid", evt_valid, 0);

    send(1000);
    check("R1 nominal", band, 2);
    send(970);
    check("R1 soft_lo boundary in-band", band, 2);

    expect_evt(1'b0, 1'b0, 32'h1000);
    send(969, 1'b1, 32'h1000);
    check("R1 soft under", band, 1);
    check("R2 throttle on", throttle, 1);

    expect_evt(1'b1, 1'b0, 32'h1000);
    send(949);
    check("R1 hard under", band, 0);
    send(950);
    check("R1 hard_lo boundary soft", band, 1);

    repeat (4) @(posedge clk); #2;
    check("R1 idle holds band", band, 1);

    send(1000); send(1000);
    repeat (3) @(posedge clk);
    send(1000);
    check("R4 held after 3 in-band", throttle, 1);
    send(1000);
    check("R4 released on 4th in-band", throttle, 0);

    expect_evt(1'b0, 1'b1, 32'h2000);
    send(1031, 1'b1, 32'h2000);
    check("R1 soft over", band, 3);
    check("R2 phantom on", phantom, 1);

    expect_evt(1'b0, 1'b0, 32'h2000);
    send(960);
    check("R3 throttle after swing", throttle, 1);
    check("R3 phantom dropped", phantom, 0);

    expect_evt(1'b1, 1'b1, 32'h2000);
    send(1051);
    check("R1 hard over", band, 4);
    check("R3 phantom after swing", phantom, 1);
    check("R3 throttle dropped", throttle, 0);

    send(1040);
    check("R5 no event inward", exp_q.size(), 0);
    check("R9 soft count", soft_cnt, 3);
    check("R9 hard count", hard_cnt, 2);

    cfg_write(3'd4, 1);
    send(1000);
    check("R10 hold=1 release", phantom, 0);

    cfg_write(3'd2, 1010);
    expect_evt(1'b0, 1'b1, 32'h2000);
    send(1011);
    check("R10 new soft_hi", band, 3);
    send(1010);
    check("R10 new soft_hi boundary", band, 2);

    // back-pressure and overwrite
    evt_ready = 1'b0;
    send(940, 1'b1, 32'h3000);
    check("R7 pending valid", evt_valid, 1);
    check("R7 pending hard", evt_hard, 1);
    repeat (3) @(posedge clk); #2;
    check("R7 held valid", evt_valid, 1);
    check("R7 held addr", evt_addr, 32'h3000);
    send(1000);
    check("R8 no ovf yet", evt_ovf, 0);
    expect_evt(1'b0, 1'b0, 32'h3000);
    send(960);
    check("R8 ovf set", evt_ovf, 1);
    check("R8 newest kept", evt_hard, 0);
    check("R9 soft before clear", soft_cnt, 5);
    check("R9 hard before clear", hard_cnt, 3);
    @(posedge clk); #2 evt_ready = 1'b1;
    @(posedge clk); #2;
    check("R7 consumed", evt_valid, 0);
    check("R8 ovf sticky", evt_ovf, 1);

    cfg_write(3'd5, 0);
    check("R9 clear soft", soft_cnt, 0);
    check("R9 clear hard", hard_cnt, 0);
    check("R8 clear ovf", evt_ovf, 0);
    check("R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule